// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the address-recognition front end of an I2C target. It oversamples the SCL and SDA bus lines with the system clock. It finds START and STOP conditions and shifts in the first byte that follows a START. That byte carries a seven-bit address, most significant bit first, and then a direction bit. The address is compared with a seven-bit value that board straps present on static input pins. The matcher therefore holds no address of its own, and the same logic can sit at any location on the bus.

When the address matches, the block pulls SDA low through an open-drain enable for the ninth SCL clock. It also gives a one-cycle pulse and latches the direction bit. When the address does not match, SDA stays released and the block ignores the bus until the next START. A repeated START runs the address match again. The data phase, clock stretching and ten-bit addressing belong to other logic.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: After reset, `sda_pull_o`, `addressed_o` and `rd_dir_o` are all 0.
- R2: The seven bits that follow a START are taken on rising SCL edges, most significant bit first. They are compared in full with `strap_addr`, so an address that differs in any bit, or that is shifted by one position, does not match.
- R3: On a match, `sda_pull_o` rises after the falling SCL edge that ends the eighth bit. It stays high through the ninth SCL high phase and falls after the falling edge that ends the ninth clock.
- R4: On a mismatch, `sda_pull_o` stays 0 for the ninth clock and `addressed_o` does not pulse.
- R5: Each match raises `addressed_o` for exactly one system clock cycle.
- R6: The eighth bit received is the direction bit, where 1 means read. On a match it is latched into `rd_dir_o`, which keeps its value until the next match.
- R7: After a mismatch, later bytes sent without a new START are ignored, even when they equal the strap address.
- R8: A START or a STOP clears the bit count. A STOP in the middle of a byte abandons that byte, and a repeated START after an acknowledged byte runs a new address match.
- R9: `sda_pull_o` is never asserted while the eight address and direction bits are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| strap_addr | input | 7 | Address set by board straps |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| addressed_o | output | 1 | One-cycle pulse on an address match |
| rd_dir_o | output | 1 | Latched direction of the last match (1 = read) |

## Verification
Each bus event passes through a two-flop synchronizer and one edge-detect flop before it reaches the state register. The outputs therefore move about three system cycles after the SCL or SDA change that caused them. The bench holds every SCL phase for 16 system cycles and samples the outputs only at the end of a phase or in the middle of it, so each result has long settled before it is read. The width of the `addressed_o` pulse is measured by counting the cycles it is high on every clock. The bench samples `sda_pull_o` both before the ninth SCL rising edge and after the ninth falling edge, which checks both ends of the acknowledge window.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int ADDR_BITS  = 7;
    localparam int FRAME_BITS = ADDR_BITS + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,   // ignoring the bus until a START
        ST_ADDR,   // shifting the address and direction bits
        ST_ACK,    // pulling SDA low during the ninth clock
        ST_HOLD    // matched; waiting for a START or a STOP
    } am_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic addr_hit(input logic [ADDR_BITS-1:0] rx,
                                      input logic [ADDR_BITS-1:0] own);
        return rx == own;
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_am_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output line_ev_t ev_o
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-1:0], line_i};
    end

    always_comb begin
        ev_o.level = pipe[STAGES-1];
        ev_o.rise  = pipe[STAGES-1] & ~pipe[STAGES];
        ev_o.fall  = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_am_pkg::*;
(
    input  line_ev_t scl_ev,
    input  line_ev_t sda_ev,
    output logic     start_o,
    output logic     stop_o
);
    // SCL must be high now and in the previous sample
    logic scl_steady_hi;
    assign scl_steady_hi = scl_ev.level & ~scl_ev.rise;
    assign start_o = sda_ev.fall & scl_steady_hi;
    assign stop_o  = sda_ev.rise & scl_steady_hi;
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
    import i2c_am_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  line_ev_t             scl_ev,
    input  line_ev_t             sda_ev,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic [ADDR_BITS-1:0] strap_addr,
    output logic                 sda_pull_o,
    output logic                 addressed_o,
    output logic                 rd_dir_o
);
    am_state_e             state;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] frame;
    logic                  frame_full;

    assign frame_full = (bit_cnt == CNT_W'(FRAME_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            frame       <= '0;
            sda_pull_o  <= 1'b0;
            addressed_o <= 1'b0;
            rd_dir_o    <= 1'b0;
        end else begin
            addressed_o <= 1'b0;
            if (start_i) begin
                state      <= ST_ADDR;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_i) begin
                state      <= ST_IDLE;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_ev.rise && !frame_full) begin
                            frame   <= {frame[FRAME_BITS-2:0], sda_ev.level};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_ev.fall && frame_full) begin
                            if (addr_hit(frame[FRAME_BITS-1:1], strap_addr)) begin
                                state       <= ST_ACK;
                                sda_pull_o  <= 1'b1;
                                addressed_o <= 1'b1;
                                rd_dir_o    <= frame[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_ev.fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: the match pulse lasts one cycle
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        addressed_o |=> !addressed_o);

    // R3: the acknowledge drive only begins together with a match
    assert_pull_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> addressed_o);

    // R4: a rejected address leaves SDA released
    assert_no_pull_on_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && frame_full && scl_ev.fall && !start_i && !stop_i &&
         !addr_hit(frame[FRAME_BITS-1:1], strap_addr)) |=> !sda_pull_o);

    // R6: the direction only changes on a match
    assert_dir_on_match_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_dir_o) |-> addressed_o);

    // R8: a START restarts the bit count
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (bit_cnt == '0 && state == ST_ADDR));

    // R9: no drive while address bits are shifting
    assert_quiet_in_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) |-> !sda_pull_o);
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
    import i2c_am_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [ADDR_BITS-1:0] strap_addr,
    output logic                 sda_pull_o,
    output logic                 addressed_o,
    output logic                 rd_dir_o
);
    line_ev_t scl_ev, sda_ev;
    logic     start_w, stop_w;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i), .ev_o(scl_ev));

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i), .ev_o(sda_ev));

    i2c_cond_detect u_cond (
        .scl_ev(scl_ev), .sda_ev(sda_ev), .start_o(start_w), .stop_o(stop_w));

    i2c_addr_fsm u_fsm (
        .clk(clk), .rst(rst), .scl_ev(scl_ev), .sda_ev(sda_ev),
        .start_i(start_w), .stop_i(stop_w), .strap_addr(strap_addr),
        .sda_pull_o(sda_pull_o), .addressed_o(addressed_o), .rd_dir_o(rd_dir_o));
endmodule

// File: tb/i2c_tgt_addr_match_tb.sv
module i2c_tgt_addr_match_tb;
    localparam int H = 16;   // system cycles per SCL phase

    typedef struct packed {
        logic [6:0] strap;
        logic [7:0] frame;   // {address, direction}
        logic       ack;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{7'h50, 8'hA0, 1'b1},
        '{7'h50, 8'hA3, 1'b0},
        '{7'h2A, 8'h55, 1'b1},
        '{7'h7F, 8'hFE, 1'b1},
        '{7'h00, 8'h02, 1'b0},
        '{7'h3C, 8'h3C, 1'b0},
        '{7'h01, 8'h03, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic host_scl = 1'b1, host_sda = 1'b1;
    logic [6:0] strap = 7'h50;
    logic sda_pull, addressed, rd_dir;
    logic sda_bus;
    int checks = 0, errors = 0, pulses = 0;
    logic in_addr = 1'b0, pull_in_addr = 1'b0, done = 1'b0;

    assign sda_bus = host_sda & ~sda_pull;

    always #2 clk = ~clk;   // 250 MHz

    i2c_tgt_addr_match u_dut (
        .clk(clk), .rst(rst), .scl_i(host_scl), .sda_i(sda_bus),
        .strap_addr(strap), .sda_pull_o(sda_pull),
        .addressed_o(addressed), .rd_dir_o(rd_dir));

    always @(posedge clk) begin
        if (!rst && addressed) pulses <= pulses + 1;
        if (!rst && in_addr && sda_pull) pull_in_addr <= 1'b1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        host_sda = 1'b1; w(H);
        host_scl = 1'b1; w(H);
        host_sda = 1'b0; w(H);
        host_scl = 1'b0; w(H);
    endtask

    task automatic do_stop();
        host_sda = 1'b0; w(H);
        host_scl = 1'b1; w(H);
        host_sda = 1'b1; w(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        in_addr = 1'b1;
        for (int i = 7; i > 7 - n; i--) begin
            host_sda = b[i]; w(H);
            host_scl = 1'b1; w(H);
            host_scl = 1'b0;
        end
        w(1);
        in_addr = 1'b0;
        w(H - 1);
    endtask

    // ninth clock; reports the pull seen before the rise, on the bus, and after
    task automatic ack_slot(output logic pre, output logic bus_low, output logic post);
        host_sda = 1'b1;
        pre = sda_pull;
        host_scl = 1'b1; w(H / 2);
        bus_low = ~sda_bus; w(H / 2);
        host_scl = 1'b0; w(H);
        post = sda_pull;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic pre, bl, post;
        int p0;
        w(5);
        check(sda_pull == 0 && addressed == 0 && rd_dir == 0, "R1 reset outputs",
              {sda_pull, addressed, rd_dir}, 0);
        rst = 1'b0; w(5);

        // table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            strap = VECS[k].strap; w(2);
            p0 = pulses;
            do_start();
            send_bits(VECS[k].frame, 8);
            ack_slot(pre, bl, post);
            check(pre == VECS[k].ack, "R3 pull before ninth rise", pre, VECS[k].ack);
            check(bl == VECS[k].ack, "R2 R4 sda low in ninth clock", bl, VECS[k].ack);
            check(post == 0, "R3 release after ninth fall", post, 0);
            check(pulses - p0 == int'(VECS[k].ack), "R5 one-cycle pulse", pulses - p0, VECS[k].ack);
            if (VECS[k].ack)
                check(rd_dir == VECS[k].frame[0], "R6 direction", rd_dir, VECS[k].frame[0]);
            do_stop();
        end

        // R6: a mismatch keeps the last direction (last vector was a read)
        strap = 7'h50; w(2);
        do_start(); send_bits(8'hA2, 8); ack_slot(pre, bl, post); do_stop();
        check(rd_dir == 1, "R6 direction held over mismatch", rd_dir, 1);

        // R7: a matching byte after a mismatch, without a new START, is ignored
        p0 = pulses;
        do_start(); send_bits(8'hA2, 8); ack_slot(pre, bl, post);
        send_bits(8'hA0, 8); ack_slot(pre, bl, post);
        check(bl == 0 && pulses == p0, "R7 ignored until START", bl, 0);
        do_stop();

        // R8: a repeated START after a match runs a new match
        do_start(); send_bits(8'hA0, 8); ack_slot(pre, bl, post);
        check(bl == 1 && rd_dir == 0, "R8 first match write", {bl, rd_dir}, 2);
        p0 = pulses;
        do_start(); send_bits(8'hA1, 8); ack_slot(pre, bl, post);
        check(bl == 1 && rd_dir == 1 && pulses == p0 + 1, "R8 repeated START read",
              {bl, rd_dir}, 3);
        do_stop();

        // R8: a STOP mid-byte abandons the partial address
        do_start(); send_bits(8'hA0, 4); do_stop();
        do_start(); send_bits(8'hA0, 8); ack_slot(pre, bl, post);
        check(bl == 1, "R8 STOP clears count", bl, 1);
        do_stop();

        check(pull_in_addr == 0, "R9 no pull during address bits", pull_in_addr, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule